// File: doc/BRIEF.md
# Four-Bank Interleaved Refill Controller

This block fetches one cache block of four words from a main memory split into four word-interleaved banks. A refill request carries a word address. The controller ignores the two low bits of that address and broadcasts the row to every bank in a single send cycle. The banks then run their long accesses side by side. When the access time has elapsed, the four words go out over a one-word return bus on four consecutive cycles, in ascending bank order. The last word is flagged.

Because the slow accesses overlap and only the narrow transfers are serialised, a refill takes one send cycle, plus one bank access, plus four transfer cycles. With the default access time of 15 cycles this is 20 cycles instead of 65. The controller also has a single-word write port, which is used to load the bank arrays while the controller is idle.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1 and rd_valid_o and rd_last_o are 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 from that edge until the edge that follows the last word.
- R3: Bits [1:0] of req_addr_i have no effect. The block base is req_addr_i with those two bits cleared.
- R4: A word address selects a bank with bits [1:0] and a row within that bank with the upper bits. Beat k of a refill returns the word stored at block base + k, which lives in bank k.
- R5: Call the accepting edge 0. Beat k (k = 0..3) is valid during the cycle after edge 1 + LAT + k. rd_valid_o is 0 at every other time, so the last word appears in cycle 1 + LAT + 4 (20 with LAT = 15).
- R6: Beats leave in bank order 0, 1, 2, 3 on consecutive cycles, and rd_bank_o equals the beat number k.
- R7: rd_last_o is 1 only together with beat 3. req_ready_o is 1 again in the cycle after that beat.
- R8: When wr_en_i is 1 while the controller is idle, the next edge writes wr_data_i to the word at wr_addr_i, using the same bank and row split as R4. A later refill returns the new value.
- R9: wr_en_i has no effect while a refill is in progress.
- R10: A write takes priority over a request in the same cycle. req_ready_o is 0 whenever wr_en_i is 1, so no request is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Refill request valid |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_addr_i | input | ROW_W+2 | Word address of the request; low two bits ignored |
| wr_en_i | input | 1 | Single-word write strobe, honoured only when idle |
| wr_addr_i | input | ROW_W+2 | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | Return beat valid |
| rd_last_o | output | 1 | Final beat of the block |
| rd_bank_o | output | 2 | Bank, and beat number, of the current word |
| rd_data_o | output | DATA_W | Returned word |

## Verification
The assertions check on every cycle that:
- the handshake holds off while the controller is busy and while a write is presented;
- the beats form one unbroken run that starts at bank 0, counts upward and ends with the flag on bank 3;
- each beat arrives exactly LAT + 2 + k cycles after acceptance, measured with a counter in the checker.

Data correctness can only be shown by the bench scenarios. These cover the row and bank split, the ignoring of the low address bits, the effect of a write on a later refill, and the fact that a write arriving mid-refill leaves storage untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int BANK_W = 2;
  localparam int NBANK  = 1 << BANK_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_XFER
  } ilv_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  parameter int LAT    = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wr_en_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              fin_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0]  row_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [DATA_W-1:0] rdata_q;

  // High in the cycle whose closing edge captures the word.
  assign fin_o   = busy_q && (cnt_q == '0);
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_row_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      row_q   <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LAT - 1);
      row_q  <= row_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        rdata_q <= mem_q[row_q];
        busy_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic              wr_en_i,
  input  logic              all_fin_i,
  output logic              req_ready_o,
  output logic              wr_go_o,
  output logic              start_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic [BANK_W-1:0] beat_o
);
  ilv_state_e        state_q;
  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] beat_q;
  logic              idle;

  assign idle        = (state_q == ST_IDLE);
  assign req_ready_o = idle && !wr_en_i;
  assign wr_go_o     = idle && wr_en_i;
  assign start_o     = (state_q == ST_SEND);
  assign row_o       = row_q;
  assign rd_valid_o  = (state_q == ST_XFER);
  assign rd_last_o   = rd_valid_o && (beat_q == BANK_W'(NBANK - 1));
  assign beat_o      = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i && req_ready_o) begin
          row_q   <= req_row_i;
          state_q <= ST_SEND;
        end
        ST_SEND: state_q <= ST_WAIT;
        ST_WAIT: if (all_fin_i) begin
          beat_q  <= '0;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          beat_q <= beat_q + 1'b1;
          if (rd_last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl
  import ilv_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  parameter int LAT    = 15,
  localparam int AW    = ROW_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              wr_go, start;
  logic [ROW_W-1:0]  row;
  logic [NBANK-1:0]  fin;
  logic [DATA_W-1:0] bank_rdata [NBANK];
  logic [BANK_W-1:0] beat;
  logic              unused_lo;

  assign unused_lo = ^req_addr_i[BANK_W-1:0];

  ilv_seq #(.ROW_W(ROW_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_row_i  (req_addr_i[AW-1:BANK_W]),
    .wr_en_i    (wr_en_i),
    .all_fin_i  (&fin),
    .req_ready_o(req_ready_o),
    .wr_go_o    (wr_go),
    .start_o    (start),
    .row_o      (row),
    .rd_valid_o (rd_valid_o),
    .rd_last_o  (rd_last_o),
    .beat_o     (beat)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .LAT(LAT)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .row_i    (row),
      .wr_en_i  (wr_go && (wr_addr_i[BANK_W-1:0] == BANK_W'(b))),
      .wr_row_i (wr_addr_i[AW-1:BANK_W]),
      .wr_data_i(wr_data_i),
      .fin_o    (fin[b]),
      .rdata_o  (bank_rdata[b])
    );
  end

  assign rd_bank_o = beat;
  assign rd_data_o = bank_rdata[beat];
endmodule

// File: rtl/ilv_refill_ctrl_chk.sv
module ilv_refill_ctrl_chk
  import ilv_pkg::*;
#(
  parameter int LAT = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              wr_en_i,
  input logic              rd_valid_o,
  input logic              rd_last_o,
  input logic [BANK_W-1:0] rd_bank_o
);
  logic [31:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (req_valid_i && req_ready_o) age_q <= 32'd1;
    else if (rd_last_o) age_q <= '0;
    else if (age_q != '0) age_q <= age_q + 32'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !rd_valid_o && !rd_last_o);
  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && req_ready_o));
  // R5
  beat_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> age_q == 32'(LAT + 2) + 32'(rd_bank_o));
  // R6
  first_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> rd_bank_o == '0);
  // R6
  bank_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_last_o) |=> rd_valid_o && rd_bank_o == $past(rd_bank_o) + 1'b1);
  // R7
  last_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o && rd_bank_o == BANK_W'(NBANK - 1));
  // R7
  last_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |=> !rd_valid_o && (req_ready_o || wr_en_i));
  // R10
  wr_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !req_ready_o);
endmodule

bind ilv_refill_ctrl ilv_refill_ctrl_chk #(.LAT(LAT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .wr_en_i    (wr_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_last_o  (rd_last_o),
  .rd_bank_o  (rd_bank_o)
);

// File: tb/ilv_refill_ctrl_test.sv
module ilv_refill_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4;
  localparam int DW    = 32;
  localparam int LAT   = 15;
  localparam int AW    = ROW_W + 2;
  localparam int NW    = 1 << AW;
  localparam logic [AW-1:0] REQ_TAB [8] = '{6'd0, 6'd4, 6'd9, 6'd15, 6'd60, 6'd33, 6'd22, 6'd47};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] req_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic req_ready, rd_valid, rd_last;
  logic [1:0] rd_bank;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] shadow [NW];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_refill_ctrl #(.ROW_W(ROW_W), .DATA_W(DW), .LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_last_o(rd_last), .rd_bank_o(rd_bank), .rd_data_o(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h5A5A0000 + 32'(a) * 32'h01030007;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a] = d;
  endtask

  // inj: drive a write into the block mid-refill (must be ignored, R9)
  task automatic run_req(input logic [AW-1:0] a, input bit inj);
    logic [AW-1:0] base;
    base = a & ~AW'(3);
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R2 ready before request", DW'(req_ready), 1);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= LAT + 5; n++) begin
      if (inj && n == 3) begin
        wr_en = 1'b1; wr_addr = base + AW'(2); wr_data = 32'hDEADBEEF;
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      begin
        int k;
        bit ev;
        k  = n - LAT - 1;
        ev = (k >= 0 && k < 4);
        chk(rd_valid == ev, "R5 beat timing", DW'(rd_valid), DW'(ev));
        if (ev) begin
          chk(rd_data == shadow[base + AW'(k)], "R4/R3/R9 beat data", rd_data, shadow[base + AW'(k)]);
          chk(rd_bank == 2'(k), "R6 bank order", DW'(rd_bank), DW'(k));
          chk(rd_last == (k == 3), "R7 last flag", DW'(rd_last), DW'(k == 3));
        end
        chk(req_ready == (n == LAT + 5), "R2 busy ready", DW'(req_ready), DW'(n == LAT + 5));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 reset ready", DW'(req_ready), 1);
    chk(rd_valid == 1'b0 && rd_last == 1'b0, "R1 reset outputs", DW'({rd_valid, rd_last}), 0);
    rst_n = 1'b1;
    for (int a = 0; a < NW; a++) write_word(AW'(a), pat(a));

    // Table walk: R3 unaligned addresses, R4 data, R5 timing
    for (int i = 0; i < 8; i++) run_req(REQ_TAB[i], 1'b0);

    // R10: write and request together; write wins, no refill starts
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd5; wr_data = 32'hCAFE0005;
    req_valid = 1'b1; req_addr = 6'd8;
    #1;
    chk(req_ready == 1'b0, "R10 ready low on write", DW'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    shadow[5] = 32'hCAFE0005;
    begin
      bit seen;
      seen = 1'b0;
      for (int n = 0; n < LAT + 8; n++) begin
        @(negedge clk);
        if (rd_valid) seen = 1'b1;
      end
      chk(!seen, "R10 request not accepted", DW'(seen), 0);
    end

    // R8: written word returned by a later refill
    run_req(6'd6, 1'b0);
    // R9: write during refill ignored, both in flight and afterwards
    run_req(6'd10, 1'b1);
    run_req(6'd8, 1'b0);
    chk(shadow[10] == pat(10), "R9 storage unchanged", shadow[10], pat(10));

    // R8 again on bank 3 of top row
    write_word(6'd63, 32'h0BADF00D);
    run_req(6'd61, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule